// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block measures how many master-clock cycles fit into one period of the sample-rate clock and decides which supported oversampling ratio the system is running at. It runs on the master clock and takes the sample-rate clock after it has been synchronised into that domain. Each period is counted from one rising edge of the sample-rate clock to the next. The count is then compared against the six ratios the converter can use, with a tolerance band around each one.

When two periods in a row match the same ratio, the block reports that ratio as an encoded value and raises its lock output. It also raises a high-rate flag for the two short ratios, which tells the downstream filter to halve its oversampling factor. A period that fits no ratio, or a sample-rate clock that stops, drops the lock and raises a shutdown-and-mute request at once. The request stays up until the ratio has been confirmed again.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is asserted and after it is released, `ratio_code` is 7, `locked` is 0, `mute_req` is 1 and `high_rate` is 0.
- R2: The measured count is the number of master-clock cycles from one rising edge of `lrc_sync` to the next. It is classified as code 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768 cycles. Code 7 means no match.
- R3: A count within plus or minus TOL (default 8) cycles of a nominal ratio, both ends included, matches that ratio. Counts 248 and 264 match 256, while 247 and 265 match nothing.
- R4: When a period matches no ratio, then in the cycle after the rising edge that ends it, `mute_req` is 1, `locked` is 0, `ratio_code` is 7 and `high_rate` is 0.
- R5: `locked` rises, `mute_req` falls and `ratio_code` takes the matched code in the cycle after a rising edge that ends the second consecutive period matching the same ratio. A single matching period after a mismatch leaves the outputs muted.
- R6: While locked, `high_rate` is 1 exactly when the locked code is 0 or 1.
- R7: While locked, a period that matches a different valid ratio drops the lock and mutes, and the outputs read code 7. The new ratio counts as the first of the two periods needed for lock.
- R8: The counter saturates at 2^CNT_W-1 (1023 by default). A saturated count is a mismatch. When `lrc_sync` stops, the block mutes in the cycle after the counter reaches 1023, without waiting for a rising edge.
- R9: The first rising edge after reset only starts a count. No period is classified until the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mclk | input | 1 | Master clock, the block's only clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_mclk |
| lrc_sync | input | 1 | Sample-rate clock already synchronised to clk_mclk |
| ratio_code | output | 3 | Locked ratio code (0..5), 7 when not locked |
| high_rate | output | 1 | 1 when locked at 128 or 192 cycles per sample |
| locked | output | 1 | Ratio confirmed by two consecutive matching periods |
| mute_req | output | 1 | Shutdown-and-mute request to the converter |

## Verification
The rising edge of `lrc_sync` is detected combinationally against a registered copy. The period that edge closes is classified and the result is registered at that same clock edge, so every output is due one cycle after the edge. The bench drives `lrc_sync` on falling clock edges and reads the outputs on the falling edge that follows the rising-edge cycle, which falls in the second cycle of the next period. The stopped-clock case is the one result not tied to an edge. It is due 1023 cycles after the last rising edge, and the bench samples well before and well after that cycle.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  localparam int          NUM_RATIOS = 6;
  localparam logic [2:0]  CODE_NONE  = 3'd7;

  // nominal master-clock cycles per sample for each code
  function automatic int nominal(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      default: return 768;
    endcase
  endfunction

  // map a measured period onto a ratio code; saturated counts never match
  function automatic logic [2:0] classify(input int cnt, input int sat, input int tol);
    logic [2:0] res;
    res = CODE_NONE;
    if (cnt < sat) begin
      for (int i = 0; i < NUM_RATIOS; i++) begin
        if (cnt >= nominal(i) - tol && cnt <= nominal(i) + tol)
          res = 3'(i);
      end
    end
    return res;
  endfunction

  function automatic logic is_high_rate(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd1);
  endfunction

endpackage

// File: rtl/mrd_edge_det.sv
module mrd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic [CNT_W-1:0] cnt,
  output logic             eval_stb
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic started_q;
  logic sat_seen_q;
  logic sat_evt;

  // one evaluation when the count first pins at saturation (stopped clock)
  assign sat_evt  = started_q && (cnt == SAT) && !sat_seen_q && !rise;
  assign eval_stb = (started_q && rise) || sat_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      started_q  <= 1'b0;
      sat_seen_q <= 1'b0;
    end else if (rise) begin
      cnt        <= CNT_W'(1);
      started_q  <= 1'b1;
      sat_seen_q <= 1'b0;
    end else begin
      if (cnt != SAT) cnt <= cnt + CNT_W'(1);
      if (sat_evt)    sat_seen_q <= 1'b1;
    end
  end

  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SAT && !rise) |=> (cnt == SAT));

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt == CNT_W'(1)));

endmodule

// File: rtl/mrd_lock_ctrl.sv
module mrd_lock_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eval_stb,
  input  logic [2:0] code,
  output logic [2:0] ratio_code,
  output logic       high_rate,
  output logic       locked,
  output logic       mute_req
);
  import mrd_pkg::*;

  logic [2:0] cand_q;
  logic       have_q;
  logic       confirm;
  logic       is_none;

  assign is_none = (code == CODE_NONE);
  assign confirm = !is_none && have_q && (code == cand_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_code <= CODE_NONE;
      high_rate  <= 1'b0;
      locked     <= 1'b0;
      mute_req   <= 1'b1;
      cand_q     <= CODE_NONE;
      have_q     <= 1'b0;
    end else if (eval_stb) begin
      if (is_none) begin
        ratio_code <= CODE_NONE;
        high_rate  <= 1'b0;
        locked     <= 1'b0;
        mute_req   <= 1'b1;
        have_q     <= 1'b0;
      end else if (confirm) begin
        ratio_code <= code;
        high_rate  <= is_high_rate(code);
        locked     <= 1'b1;
        mute_req   <= 1'b0;
      end else begin
        cand_q <= code;
        have_q <= 1'b1;
        if (locked && code != ratio_code) begin
          ratio_code <= CODE_NONE;
          high_rate  <= 1'b0;
          locked     <= 1'b0;
          mute_req   <= 1'b1;
        end
      end
    end
  end

  a_r4_mute_on_none: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && code == CODE_NONE) |=> (mute_req && !locked));

  a_r5_lock_needs_eval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(eval_stb));

  a_r5_lock_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !mute_req);

  a_r6_hr_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !high_rate);

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter int CNT_W = 10,
  parameter int TOL   = 8
) (
  input  logic       clk_mclk,
  input  logic       rst_n,
  input  logic       lrc_sync,
  output logic [2:0] ratio_code,
  output logic       high_rate,
  output logic       locked,
  output logic       mute_req
);
  import mrd_pkg::*;

  localparam int SAT_VAL = (1 << CNT_W) - 1;

  logic             lrc_rise;
  logic [CNT_W-1:0] period_cnt;
  logic             eval_stb;
  logic [2:0]       meas_code;

  mrd_edge_det u_edge (
    .clk    (clk_mclk),
    .rst_n  (rst_n),
    .sig_in (lrc_sync),
    .rise   (lrc_rise)
  );

  mrd_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk_mclk),
    .rst_n    (rst_n),
    .rise     (lrc_rise),
    .cnt      (period_cnt),
    .eval_stb (eval_stb)
  );

  assign meas_code = classify(int'(period_cnt), SAT_VAL, TOL);

  mrd_lock_ctrl u_lock (
    .clk        (clk_mclk),
    .rst_n      (rst_n),
    .eval_stb   (eval_stb),
    .code       (meas_code),
    .ratio_code (ratio_code),
    .high_rate  (high_rate),
    .locked     (locked),
    .mute_req   (mute_req)
  );

  a_r8_sat_is_none: assert property (@(posedge clk_mclk) disable iff (!rst_n)
    (period_cnt == CNT_W'(SAT_VAL)) |-> (meas_code == CODE_NONE));

endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrc = 1'b0;
  logic [2:0] ratio_code;
  logic       high_rate, locked, mute_req;
  int         checks = 0;
  int         failures = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  mclk_ratio_detect u_dut (
    .clk_mclk   (clk),
    .rst_n      (rst_n),
    .lrc_sync   (lrc),
    .ratio_code (ratio_code),
    .high_rate  (high_rate),
    .locked     (locked),
    .mute_req   (mute_req)
  );

  // expectation packing: code<<3 | locked<<2 | mute<<1 | high_rate
  localparam int NV = 23;
  localparam int VLEN[NV] = '{256, 260, 248, 264, 265, 256, 256, 128, 130, 192, 185,
                              384, 392, 512, 505, 768, 776, 300, 512, 247, 512, 768, 768};
  localparam int VEXP[NV] = '{58, 20, 20, 20, 58, 58, 20, 58, 5, 58, 13,
                              58, 28, 58, 36, 58, 44, 58, 58, 58, 58, 58, 44};
  localparam int EXP_IDLE = 58;

  task automatic check_out(input int exp, input string tag);
    int act;
    act = {26'd0, ratio_code, locked, mute_req, high_rate};
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: code/locked/mute/hr actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
               tag, ratio_code, locked, mute_req, high_rate,
               exp >> 3, (exp >> 2) & 1, (exp >> 1) & 1, exp & 1);
    end
  endtask

  // one LRC period of n cycles; the rising edge is in the first cycle and
  // the result it produced is sampled on the falling edge of the second.
  task automatic drive_period(input int n, input bit chk, input int exp, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1 && chk) check_out(exp, tag);
      lrc = (i < n / 2);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset values
    repeat (4) @(negedge clk);
    check_out(EXP_IDLE, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out(EXP_IDLE, "R1 after release");

    // table walk: R2 R3 R4 R5 R6 R7; first entry checks R9 (no eval on first edge)
    for (int i = 0; i < NV; i++) begin
      if (i == 0) drive_period(VLEN[i], 1'b1, EXP_IDLE, "R9 first edge only primes");
      else        drive_period(VLEN[i], 1'b1, VEXP[i-1], $sformatf("R2 R3 R5 R7 vector %0d", i - 1));
    end
    drive_period(256, 1'b1, VEXP[NV-1], "R2 R5 vector 22");

    // R8: stopped LRC, still locked at 768 before saturation, muted after
    repeat (700) @(negedge clk);
    check_out(44, "R8 before saturation");
    repeat (100) @(negedge clk);
    check_out(EXP_IDLE, "R8 stopped clock mutes");

    // recovery: saturated period evaluates as none, then two 256 periods lock
    drive_period(256, 1'b1, EXP_IDLE, "R8 saturated count is mismatch");
    drive_period(256, 1'b1, EXP_IDLE, "R5 single match stays muted");
    drive_period(200, 1'b1, 20, "R5 relock at 256");
    drive_period(200, 1'b1, 58, "R4 period of 200 mutes");

    // R1: reset mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_out(EXP_IDLE, "R1 reset mid-run");
    rst_n = 1'b1;
    finish_run();
  end

endmodule